// File: doc/BRIEF.md
# Prioritized Bus Master Arbiter

This block is the central referee for a shared system bus whose masters run without a common clock. Would-be masters raise either one of four priority-ranked request lines or a separate direct-memory-access request line. The arbiter hands back one grant at a time. The grant goes to the DMA requester if it is asking, and otherwise to the highest-ranked level. The grant stays up until the chosen device confirms its selection.

After confirming, the selected device waits for the current owner to release the busy line before it drives data. The arbiter reports that moment on a dedicated permission output. The next owner can be picked while the current owner is still moving data, so arbitration overlaps with transfers.

A grant that nobody confirms within a run-time limit is withdrawn, and arbitration starts again. All bus-side inputs pass through a configurable synchronizer before the control logic uses them. A bus-init input puts the arbiter back into its idle state.

Top module: `bus_arb_top`

## Requirements
- R1: After reset, every grant output and `bus_go` are 0.
- R2: When `dma_req` is active, `dma_gnt` is the grant issued, whatever the priority lines carry.
- R3: Among the priority lines with no DMA request, the set bit with the highest index wins. Bit 3 is the top level and bit 0 the bottom level.
- R4: At most one of `dma_gnt` and `irq_gnt` is 1 in any cycle.
- R5: A grant stays asserted until `sel_ack` is seen. It is then withdrawn on the third rising edge after `sel_ack` rises.
- R6: While `sel_ack` is held high, no new grant is issued. After `sel_ack` falls, a pending request is granted on the fourth rising edge.
- R7: `bus_go` is 1 only while the selected device holds `sel_ack` and the synchronized `bus_busy` is 0. It is never 1 together with a grant.
- R8: If a grant sees no `sel_ack`, it is withdrawn after being high for `tmo_limit`+1 cycles. If the request is still present, a fresh grant follows one cycle later.
- R9: A new grant may be issued while `bus_busy` is still held by the current owner.
- R10: A cycle with `bus_init` high clears all grants and `bus_go` at the next rising edge.
- R11: With the default two synchronizer stages, a request raised from idle produces its grant on the third rising edge.
- R12: Once a grant is issued, it does not move to a different requester, even if a higher-ranked request arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_init | input | 1 | Synchronous return to idle |
| irq_req | input | NUM_LVL | Priority request lines, highest index ranks highest |
| dma_req | input | 1 | DMA request, outranks all priority lines |
| sel_ack | input | 1 | Selection confirmation from the granted device |
| bus_busy | input | 1 | Current owner is holding the bus |
| tmo_limit | input | TMO_W | Confirmation timeout count |
| irq_gnt | output | NUM_LVL | Per-level grants |
| dma_gnt | output | 1 | DMA grant |
| bus_go | output | 1 | Selected device may take the bus |

## Verification
Four properties are checked on every cycle:
- no more than one grant is active;
- an issued grant never switches to another requester;
- `bus_go` never coincides with a grant;
- no grant outlives the timeout window, and `bus_init` empties the outputs.

The priority order is shown only by the bench's scenarios, which apply request patterns and compare the grant that comes out. The same holds for:
- the exact synchronizer latency;
- the refusal to grant while a confirmation is held;
- the re-grant after a timeout;
- granting while the busy line is still asserted.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
   // Grant controller phases
   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,  // free to pick a new owner
      ARB_OFFER = 2'd1,  // grant out, awaiting confirmation
      ARB_HELD  = 2'd2   // confirmation held by selected device
   } arb_state_e;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("arb_sync: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
      assign q = stage_q[STAGES-1];
   end
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] win
);
   if (N < 1) begin : g_bad_n
      $error("arb_pick: N must be at least 1");
   end

   // above[i] is set when any request at index i or higher is active
   logic [N:0] above;
   assign above[N] = 1'b0;

   for (genvar i = N - 1; i >= 0; i--) begin : g_rank
      assign above[i] = above[i+1] | req[i];
      assign win[i]   = req[i] & ~above[i+1];
   end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
   import bus_arb_pkg::*;
#(
   parameter int N     = 5,
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic [N-1:0]     s_req,
   input  logic             s_ack,
   input  logic             s_busy,
   input  logic [TMO_W-1:0] tmo_limit,
   input  logic [N-1:0]     pick,
   output logic [N-1:0]     gnt,
   output logic             go
);
   arb_state_e       state_q;
   logic [N-1:0]     gnt_q;
   logic [TMO_W-1:0] wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ARB_IDLE;
         gnt_q   <= '0;
         wait_q  <= '0;
      end else if (init) begin
         state_q <= ARB_IDLE;
         gnt_q   <= '0;
         wait_q  <= '0;
      end else begin
         case (state_q)
            ARB_IDLE: begin
               // a confirmation still on the bus blocks any new offer
               if (!s_ack && (|s_req)) begin
                  gnt_q   <= pick;
                  wait_q  <= '0;
                  state_q <= ARB_OFFER;
               end
            end
            ARB_OFFER: begin
               if (s_ack) begin
                  gnt_q   <= '0;
                  state_q <= ARB_HELD;
               end else if (wait_q == tmo_limit) begin
                  gnt_q   <= '0;
                  state_q <= ARB_IDLE;
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            ARB_HELD: begin
               if (!s_ack) state_q <= ARB_IDLE;
            end
            default: begin
               state_q <= ARB_IDLE;
               gnt_q   <= '0;
            end
         endcase
      end
   end

   assign gnt = gnt_q;
   assign go  = (state_q == ARB_HELD) && !s_busy;
endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top #(
   parameter int NUM_LVL     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int TMO_W       = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_init,
   input  logic [NUM_LVL-1:0] irq_req,
   input  logic               dma_req,
   input  logic               sel_ack,
   input  logic               bus_busy,
   input  logic [TMO_W-1:0]   tmo_limit,
   output logic [NUM_LVL-1:0] irq_gnt,
   output logic               dma_gnt,
   output logic               bus_go
);
   localparam int NREQ = NUM_LVL + 1;   // DMA sits above all levels
   localparam int SW   = NREQ + 2;      // requests, ack, busy

   if (NUM_LVL < 1) begin : g_bad_lvl
      $error("bus_arb_top: NUM_LVL must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("bus_arb_top: SYNC_STAGES must not be negative");
   end
   if (TMO_W < 1) begin : g_bad_tmo
      $error("bus_arb_top: TMO_W must be at least 1");
   end

   logic [SW-1:0]   raw_in, syn_in;
   logic [NREQ-1:0] s_req, pick, gnt;
   logic            s_ack, s_busy;

   assign raw_in = {bus_busy, sel_ack, dma_req, irq_req};

   arb_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign s_req  = syn_in[NREQ-1:0];
   assign s_ack  = syn_in[NREQ];
   assign s_busy = syn_in[NREQ+1];

   arb_pick #(.N(NREQ)) u_pick (
      .req (s_req),
      .win (pick)
   );

   arb_ctrl #(.N(NREQ), .TMO_W(TMO_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (bus_init),
      .s_req     (s_req),
      .s_ack     (s_ack),
      .s_busy    (s_busy),
      .tmo_limit (tmo_limit),
      .pick      (pick),
      .gnt       (gnt),
      .go        (bus_go)
   );

   assign irq_gnt = gnt[NUM_LVL-1:0];
   assign dma_gnt = gnt[NUM_LVL];
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk #(
   parameter int NUM_LVL = 4,
   parameter int TMO_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_init,
   input logic [TMO_W-1:0]   tmo_limit,
   input logic [NUM_LVL-1:0] irq_gnt,
   input logic               dma_gnt,
   input logic               bus_go
);
   logic [NUM_LVL:0] gv;
   assign gv = {dma_gnt, irq_gnt};

   // cycles the grant vector has already been high before this one
   logic [TMO_W:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               run_q <= '0;
      else if (gv == '0)        run_q <= '0;
      else if (run_q != '1)     run_q <= run_q + 1'b1;
   end

   a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gv));

   a_r12_grant_frozen: assert property (@(posedge clk) disable iff (!rst_n || bus_init)
      ((|gv) && (|$past(gv))) |-> (gv == $past(gv)));

   a_r7_go_excl: assert property (@(posedge clk) disable iff (!rst_n)
      bus_go |-> (gv == '0));

   a_r8_timeout_window: assert property (@(posedge clk) disable iff (!rst_n || bus_init)
      (|gv) |-> (run_q <= {1'b0, tmo_limit}));

   a_r10_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
      bus_init |=> ((gv == '0) && !bus_go));
endmodule

bind bus_arb_top bus_arb_chk #(.NUM_LVL(NUM_LVL), .TMO_W(TMO_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_init  (bus_init),
   .tmo_limit (tmo_limit),
   .irq_gnt   (irq_gnt),
   .dma_gnt   (dma_gnt),
   .bus_go    (bus_go)
);

// File: tb/tb_bus_arb_top.sv
`timescale 1ns/1ps
module tb_bus_arb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_init = 1'b0;
   logic [3:0] irq_req = '0;
   logic       dma_req = 1'b0;
   logic       sel_ack = 1'b0;
   logic       bus_busy = 1'b0;
   logic [7:0] tmo_limit = 8'd20;
   logic [3:0] irq_gnt;
   logic       dma_gnt;
   logic       bus_go;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bus_arb_top dut (
      .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .irq_req(irq_req),
      .dma_req(dma_req), .sel_ack(sel_ack), .bus_busy(bus_busy),
      .tmo_limit(tmo_limit), .irq_gnt(irq_gnt), .dma_gnt(dma_gnt),
      .bus_go(bus_go)
   );

   // request pattern {dma, lvl3..lvl0} and expected grant, same layout
   localparam logic [9:0] VEC [0:7] = '{
      {5'b00001, 5'b00001},   // R3 lone bottom level
      {5'b00010, 5'b00010},
      {5'b00100, 5'b00100},
      {5'b01000, 5'b01000},   // R3 lone top level
      {5'b00101, 5'b00100},   // R3 higher of two
      {5'b01111, 5'b01000},   // R3 all levels
      {5'b10000, 5'b10000},   // R2 DMA alone
      {5'b11111, 5'b10000}    // R2 DMA beats all levels
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // observed value {bus_go, dma_gnt, irq_gnt}
   task automatic check(input string tag, input logic [5:0] exp);
      logic [5:0] act;
      act = {bus_go, dma_gnt, irq_gnt};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%b exp=%b", tag, act, exp);
      end
   endtask

   task automatic release_all();
      sel_ack = 1'b1;
      tick(3);
      sel_ack = 1'b0;
      irq_req = '0;
      dma_req = 1'b0;
      tick(4);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      check("R1 reset outputs", 6'b0);
      rst_n = 1'b1;
      tick(2);
      check("R1 idle after reset", 6'b0);

      // table walk
      for (int v = 0; v < 8; v++) begin
         {dma_req, irq_req} = VEC[v][9:5];
         tick(3);
         check("R2/R3/R11 grant choice", {1'b0, VEC[v][4:0]});
         tick(2);
         check("R5 grant held without ack", {1'b0, VEC[v][4:0]});
         sel_ack = 1'b1;
         tick(3);
         check("R5/R7 grant withdrawn, go up", 6'b100000);
         sel_ack = 1'b0;
         irq_req = '0;
         dma_req = 1'b0;
         tick(4);
         check("R7 go drops after ack", 6'b0);
      end

      // R11 exact latency
      irq_req = 4'b0001;
      tick(2);
      check("R11 no grant before third edge", 6'b0);
      tick(1);
      check("R11 grant at third edge", 6'b000001);
      release_all();

      // R12 grant does not move
      irq_req = 4'b0001;
      tick(3);
      dma_req = 1'b1;
      irq_req = 4'b1001;
      tick(4);
      check("R12 grant frozen", 6'b000001);
      release_all();

      // R6, R7, R9 with busy held by previous owner
      irq_req = 4'b0001;
      tick(3);
      sel_ack = 1'b1;
      bus_busy = 1'b1;
      tick(3);
      check("R7 go held off by busy", 6'b0);
      irq_req = 4'b0100;
      tick(6);
      check("R6 no grant during ack", 6'b0);
      sel_ack = 1'b0;
      tick(3);
      check("R6 not yet regranted", 6'b0);
      tick(1);
      check("R9 grant while busy high", 6'b000100);
      sel_ack = 1'b1;
      bus_busy = 1'b0;
      tick(3);
      check("R7 go after busy release", 6'b100000);
      sel_ack = 1'b0;
      irq_req = '0;
      tick(4);

      // R8 timeout and restart
      tmo_limit = 8'd3;
      irq_req = 4'b0010;
      tick(3);
      check("R8 first grant", 6'b000010);
      tick(3);
      check("R8 still inside window", 6'b000010);
      tick(1);
      check("R8 withdrawn on timeout", 6'b0);
      tick(1);
      check("R8 regranted", 6'b000010);
      irq_req = '0;
      tick(8);
      check("R8 quiet after expiry", 6'b0);
      tmo_limit = 8'd20;

      // R10 bus init
      irq_req = 4'b1000;
      tick(3);
      check("R10 setup grant", 6'b001000);
      bus_init = 1'b1;
      tick(1);
      check("R10 init clears", 6'b0);
      bus_init = 1'b0;
      tick(1);
      check("R10 arbitration resumes", 6'b001000);
      release_all();
      check("R1 idle at end", 6'b0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule